// File: doc/BRIEF.md
# Base-Page Effective Address Generator

This block works out the 16-bit effective address, or the immediate operand, for the data-addressing modes of an 8-bit processor. A sequencer starts it with a one-cycle pulse and a mode code. The block then pulls the operand bytes that follow the opcode over a byte-wide request/valid handshake, one byte per accepted cycle, always low byte first. When the last byte arrives, it returns a 16-bit result, a flag that says whether the result is an address or data, and a one-cycle done strobe.

In the base-page modes, the high address byte comes from a programmable base register B instead of being fixed at zero. Indexing in those modes wraps inside the low byte. The absolute indexed modes add the zero-extended index to the full 16-bit operand, so a carry can reach the high byte. Implied mode fetches nothing and reports a null result, because its target register is fixed by the opcode (the accumulator by default).

Top module: `ea_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `done` and `opnd_req` are low in the following cycle, and any fetch in progress is abandoned.
- R2: Mode code 0 (implied) requests no operand byte. `done` rises in the cycle after the accepted start, with `result` = 0 and `res_is_addr` = 0.
- R3: Mode code 1 (immediate byte) fetches one byte D. The result is `{8'h00, D}` with `res_is_addr` = 0.
- R4: Mode code 2 (immediate word) fetches two bytes, the low byte L and then the high byte H. The result is `{H, L}` with `res_is_addr` = 0.
- R5: Mode code 3 (base page) fetches one byte L. The result is `{B, L}` with `res_is_addr` = 1, where B is `base_b`.
- R6: Mode codes 4 (base page + X) and 5 (base page + Y) fetch one byte L. The result is `{B, (L + index) mod 256}` with `res_is_addr` = 1, and the low-byte carry is dropped.
- R7: Mode code 6 (absolute) fetches L and then H. The result is `{H, L}` with `res_is_addr` = 1.
- R8: Mode codes 7 (absolute + X) and 8 (absolute + Y) fetch L and then H. The result is `({H, L} + index) mod 65536` with `res_is_addr` = 1.
- R9: `opnd_req` stays high until `opnd_valid` is seen. A byte is taken only in a cycle where both are high. `done` rises in the cycle after the final byte is taken, and `opnd_req` is low while `done` is high.
- R10: A `start` that arrives while an operation is in progress has no effect. `idx_x`, `idx_y` and `base_b` are sampled only at the accepted start, so later changes to them do not alter the result.
- R11: Mode codes 9 to 15 behave as implied mode (R2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| mode | input | 4 | Addressing mode code (see R2 to R11) |
| idx_x | input | 8 | X index register value |
| idx_y | input | 8 | Y index register value |
| base_b | input | 8 | Base-page register B value |
| opnd_req | output | 1 | Request for the next operand byte |
| opnd_valid | input | 1 | Operand byte present on `opnd_byte` |
| opnd_byte | input | 8 | Operand byte bus |
| done | output | 1 | One-cycle completion strobe |
| result | output | 16 | Effective address or immediate data |
| res_is_addr | output | 1 | 1 when `result` is an address, 0 for data or none |

## Verification
A corrupted fetch state shows up at the ports within one cycle. The symptoms are a request that drops before its byte arrives, an extra or missing byte request, or a done strobe that lands one handshake early or late. A wrong captured byte or index snapshot only becomes visible at the done cycle, as a wrong result value or a wrong high byte in base-page modes. The bench therefore compares every result against arithmetic computed in the bench. It also scrambles the index and base inputs right after each start and pulses start during stalls, so a snapshot or busy-guard fault changes the reported value.

// File: rtl/ea_gen_pkg.sv
// Package: shared mode codes, fetch states and operand-count helper for
// the effective address generator. Assumes a 4-bit mode code.
package ea_gen_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        EA_IMPL  = 4'd0,
        EA_IMM8  = 4'd1,
        EA_IMM16 = 4'd2,
        EA_BP    = 4'd3,
        EA_BPX   = 4'd4,
        EA_BPY   = 4'd5,
        EA_ABS   = 4'd6,
        EA_ABSX  = 4'd7,
        EA_ABSY  = 4'd8
    } ea_mode_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_LO   = 2'd1,
        FS_HI   = 2'd2
    } fetch_state_e;

    // Number of operand bytes a mode consumes; unknown codes need none.
    function automatic logic [1:0] operand_count(input logic [MODE_W-1:0] m);
        logic [1:0] n;
        case (m)
            EA_IMM8, EA_BP, EA_BPX, EA_BPY:     n = 2'd1;
            EA_IMM16, EA_ABS, EA_ABSX, EA_ABSY: n = 2'd2;
            default:                            n = 2'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ea_fetch_fsm.sv
// Module: operand fetch sequencer. Accepts a start only when idle, then
// requests one or two operand bytes, low byte first, and raises fin in the
// cycle the last byte is taken (or at start for byte-less modes).
// Assumes the requester holds opnd_byte valid while opnd_valid is high.
module ea_fetch_fsm
    import ea_gen_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [MODE_W-1:0]    mode_in,
    input  logic                 opnd_valid,
    input  logic [DATA_W-1:0]    opnd_byte,
    output logic                 opnd_req,
    output logic                 busy,
    output logic                 accept,
    output logic                 fin,
    output logic [MODE_W-1:0]    mode_eff,
    output logic [DATA_W-1:0]    lo_eff,
    output logic [DATA_W-1:0]    hi_eff
);

    fetch_state_e          state;
    logic [MODE_W-1:0]     mode_q;
    logic [DATA_W-1:0]     lo_q;
    logic [1:0]            cnt_in;
    logic [1:0]            cnt_q;

    // Operand counts for the incoming and the latched mode.
    always_comb begin
        cnt_in = operand_count(mode_in);
        cnt_q  = operand_count(mode_q);
    end

    // Handshake outputs and the completion condition.
    always_comb begin
        busy     = (state != FS_IDLE);
        accept   = start && (state == FS_IDLE);
        opnd_req = busy;
        fin      = (accept && (cnt_in == 2'd0))
                || ((state == FS_LO) && opnd_valid && (cnt_q == 2'd1))
                || ((state == FS_HI) && opnd_valid);
        mode_eff = (state == FS_IDLE) ? mode_in : mode_q;
        lo_eff   = (state == FS_LO) ? opnd_byte : lo_q;
        hi_eff   = (state == FS_HI) ? opnd_byte : '0;
    end

    // State, latched mode and captured low byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= FS_IDLE;
            mode_q <= '0;
            lo_q   <= '0;
        end else begin
            case (state)
                FS_IDLE: if (start) begin
                    mode_q <= mode_in;
                    state  <= (cnt_in == 2'd0) ? FS_IDLE : FS_LO;
                end
                FS_LO: if (opnd_valid) begin
                    lo_q  <= opnd_byte;
                    state <= (cnt_q == 2'd2) ? FS_HI : FS_IDLE;
                end
                FS_HI: if (opnd_valid) begin
                    state <= FS_IDLE;
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ea_ctx_snap.sv
// Module: register context snapshot. Holds X, Y and B as they were at the
// accepted start so that later changes on the inputs cannot leak into an
// operation in flight. Assumes accept is a single-cycle pulse.
module ea_ctx_snap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] idx_x,
    input  logic [DATA_W-1:0] idx_y,
    input  logic [DATA_W-1:0] base_b,
    output logic [DATA_W-1:0] x_q,
    output logic [DATA_W-1:0] y_q,
    output logic [DATA_W-1:0] b_q
);

    // Capture the register context on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
            b_q <= '0;
        end else if (accept) begin
            x_q <= idx_x;
            y_q <= idx_y;
            b_q <= base_b;
        end
    end

endmodule

// File: rtl/ea_addr_calc.sv
// Module: combinational result former. From the mode, the operand bytes and
// the register snapshot it builds the address or immediate data. Base-page
// indexing wraps inside the low byte; absolute indexing wraps at 16 bits.
module ea_addr_calc
    import ea_gen_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    input  logic [DATA_W-1:0] x_q,
    input  logic [DATA_W-1:0] y_q,
    input  logic [DATA_W-1:0] b_q,
    output logic [ADDR_W-1:0] res,
    output logic              is_addr
);

    localparam int NIDX = 2;

    logic [DATA_W-1:0] idx     [NIDX];
    logic [DATA_W-1:0] bp_sum  [NIDX];
    logic [ADDR_W-1:0] abs_sum [NIDX];

    assign idx[0] = x_q;
    assign idx[1] = y_q;

    // One narrow and one wide adder per index register.
    for (genvar i = 0; i < NIDX; i++) begin : g_idx
        assign bp_sum[i]  = lo + idx[i];
        assign abs_sum[i] = {hi, lo} + {{DATA_W{1'b0}}, idx[i]};
    end

    // Select the result and its kind by mode.
    always_comb begin
        res     = '0;
        is_addr = 1'b1;
        case (mode)
            EA_IMM8:  begin res = {{DATA_W{1'b0}}, lo}; is_addr = 1'b0; end
            EA_IMM16: begin res = {hi, lo};             is_addr = 1'b0; end
            EA_BP:    res = {b_q, lo};
            EA_BPX:   res = {b_q, bp_sum[0]};
            EA_BPY:   res = {b_q, bp_sum[1]};
            EA_ABS:   res = {hi, lo};
            EA_ABSX:  res = abs_sum[0];
            EA_ABSY:  res = abs_sum[1];
            default:  is_addr = 1'b0;
        endcase
    end

endmodule

// File: rtl/ea_gen.sv
// Module: effective address generator top. Chains the fetch sequencer, the
// context snapshot and the result former, and registers the result with a
// one-cycle done strobe. Assumes synchronous active-low reset.
module ea_gen
    import ea_gen_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [DATA_W-1:0] idx_x,
    input  logic [DATA_W-1:0] idx_y,
    input  logic [DATA_W-1:0] base_b,
    output logic              opnd_req,
    input  logic              opnd_valid,
    input  logic [DATA_W-1:0] opnd_byte,
    output logic              done,
    output logic [ADDR_W-1:0] result,
    output logic              res_is_addr
);

    logic              busy;
    logic              accept;
    logic              fin;
    logic [MODE_W-1:0] mode_eff;
    logic [DATA_W-1:0] lo_eff;
    logic [DATA_W-1:0] hi_eff;
    logic [DATA_W-1:0] x_q;
    logic [DATA_W-1:0] y_q;
    logic [DATA_W-1:0] b_q;
    logic [ADDR_W-1:0] calc_res;
    logic              calc_is_addr;

    ea_fetch_fsm #(.DATA_W(DATA_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode_in    (mode),
        .opnd_valid (opnd_valid),
        .opnd_byte  (opnd_byte),
        .opnd_req   (opnd_req),
        .busy       (busy),
        .accept     (accept),
        .fin        (fin),
        .mode_eff   (mode_eff),
        .lo_eff     (lo_eff),
        .hi_eff     (hi_eff)
    );

    ea_ctx_snap #(.DATA_W(DATA_W)) i_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .idx_x  (idx_x),
        .idx_y  (idx_y),
        .base_b (base_b),
        .x_q    (x_q),
        .y_q    (y_q),
        .b_q    (b_q)
    );

    ea_addr_calc #(.DATA_W(DATA_W)) i_calc (
        .mode    (mode_eff),
        .lo      (lo_eff),
        .hi      (hi_eff),
        .x_q     (x_q),
        .y_q     (y_q),
        .b_q     (b_q),
        .res     (calc_res),
        .is_addr (calc_is_addr)
    );

    // Register the outcome and pulse done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            result      <= '0;
            res_is_addr <= 1'b0;
        end else begin
            done <= fin;
            if (fin) begin
                result      <= calc_res;
                res_is_addr <= calc_is_addr;
            end
        end
    end

endmodule

// File: rtl/ea_gen_chk.sv
// Module: protocol and result checker for ea_gen, bound to every instance.
// Keeps its own record of the mode and B value at each accepted start.
module ea_gen_chk
    import ea_gen_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic [MODE_W-1:0] mode,
    input logic [DATA_W-1:0] base_b,
    input logic              opnd_req,
    input logic              opnd_valid,
    input logic              done,
    input logic [ADDR_W-1:0] result,
    input logic              res_is_addr
);

    logic [MODE_W-1:0] seen_mode;
    logic [DATA_W-1:0] seen_b;

    // Record what the accepted start asked for.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_mode <= '0;
            seen_b    <= '0;
        end else if (start && !busy) begin
            seen_mode <= mode;
            seen_b    <= base_b;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!done && !opnd_req)); // R1

    AST_NULL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (seen_mode == 4'd0 || seen_mode > 4'd8))
        |-> (result == '0 && !res_is_addr)); // R2

    AST_DATA_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (seen_mode == 4'd1 || seen_mode == 4'd2)) |-> !res_is_addr); // R3

    AST_BASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (done && seen_mode >= 4'd3 && seen_mode <= 4'd5)
        |-> (res_is_addr && result[ADDR_W-1:DATA_W] == seen_b)); // R5

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd_req && !opnd_valid) |=> opnd_req); // R9

    AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !opnd_req); // R9

endmodule

bind ea_gen ea_gen_chk #(.DATA_W(DATA_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .mode        (mode),
    .base_b      (base_b),
    .opnd_req    (opnd_req),
    .opnd_valid  (opnd_valid),
    .done        (done),
    .result      (result),
    .res_is_addr (res_is_addr)
);

// File: tb/test_ea_gen.sv
`timescale 1ns/100ps
module test_ea_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [3:0]  mode;
    logic [7:0]  idx_x, idx_y, base_b;
    logic        opnd_req;
    logic        opnd_valid;
    logic [7:0]  opnd_byte;
    logic        done;
    logic [15:0] result;
    logic        res_is_addr;

    int vectors = 0;
    int fails   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ea_gen i_ea_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .idx_x(idx_x), .idx_y(idx_y), .base_b(base_b),
        .opnd_req(opnd_req), .opnd_valid(opnd_valid), .opnd_byte(opnd_byte),
        .done(done), .result(result), .res_is_addr(res_is_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int nbytes(input int m);
        if (m == 1 || m == 3 || m == 4 || m == 5) return 1;
        if (m == 2 || m == 6 || m == 7 || m == 8) return 2;
        return 0;
    endfunction

    function automatic string tag_of(input int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4, 5: return "R6";
            6: return "R7";
            7, 8: return "R8";
            default: return "R11";
        endcase
    endfunction

    // Expected {is_addr, result} from the requirements.
    function automatic logic [16:0] expv(input int m, lo, hi, x, y, b);
        case (m)
            1: return {1'b0, 16'(lo)};
            2: return {1'b0, 16'(hi * 256 + lo)};
            3: return {1'b1, 16'(b * 256 + lo)};
            4: return {1'b1, 16'(b * 256 + ((lo + x) % 256))};
            5: return {1'b1, 16'(b * 256 + ((lo + y) % 256))};
            6: return {1'b1, 16'(hi * 256 + lo)};
            7: return {1'b1, 16'((hi * 256 + lo + x) % 65536)};
            8: return {1'b1, 16'((hi * 256 + lo + y) % 65536)};
            default: return 17'd0;
        endcase
    endfunction

    task automatic run(input int m, lo, hi, x, y, b, stall);
        int n = nbytes(m);
        logic [16:0] e = expv(m, lo, hi, x, y, b);
        string t = tag_of(m);
        @(negedge clk);
        start = 1'b1; mode = 4'(m);
        idx_x = 8'(x); idx_y = 8'(y); base_b = 8'(b);
        @(negedge clk);
        start = 1'b0; idx_x = ~idx_x; idx_y = ~idx_y; base_b = ~base_b;
        for (int k = 0; k < n; k++) begin
            for (int s = 0; s < stall; s++) begin
                chk("R9 request held", 32'(opnd_req), 32'd1);
                start = 1'b1; mode = 4'd0; opnd_byte = 8'h5A;
                @(negedge clk);
            end
            chk("R9 request", 32'(opnd_req), 32'd1);
            start = 1'b0; opnd_valid = 1'b1;
            opnd_byte = (k == 0) ? 8'(lo) : 8'(hi);
            @(negedge clk);
            opnd_valid = 1'b0;
        end
        chk({t, " done"}, 32'(done), 32'd1);
        chk({t, " result"}, 32'(result), 32'(e[15:0]));
        chk({t, " kind"}, 32'(res_is_addr), 32'(e[16]));
        chk("R9 no request at done", 32'(opnd_req), 32'd0);
        @(negedge clk);
        chk("R10 busy start ignored", {30'd0, done, opnd_req}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; mode = '0; idx_x = '0; idx_y = '0;
        base_b = '0; opnd_valid = 1'b0; opnd_byte = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset done", 32'(done), 32'd0);
        chk("R1 reset request", 32'(opnd_req), 32'd0);
        rst_n = 1'b1;

        // Reset in the middle of a two-byte fetch.
        @(negedge clk); start = 1'b1; mode = 4'd6;
        @(negedge clk); start = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 abort fetch", {30'd0, done, opnd_req}, 32'd0);

        // Corners: carries, wraps, all-zero, all-ones.
        for (int m = 0; m < 16; m++) begin
            run(m, 255, 255, 1, 1, 255, 0);
            run(m, 0, 0, 0, 0, 0, 1);
            run(m, 128, 127, 128, 200, 18, 2);
            run(m, 255, 255, 255, 255, 0, 0);
        end

        // Patterned sweep over every mode code.
        for (int m = 0; m < 16; m++)
            for (int v = 0; v < 40; v++)
                run(m, (v * 37 + m * 11) % 256, (v * 53 + 7) % 256,
                    (v * 29 + m) % 256, (255 - v * 13 + 520) % 256,
                    (v * 71) % 256, v % 3);

        // Grid of low byte against index for the indexed modes.
        for (int lo = 0; lo < 256; lo += 15)
            for (int x = 0; x < 256; x += 15) begin
                run(4, lo, 0, x, 255 - x, lo ^ x, 0);
                run(5, lo, 0, 255 - x, x, 3, 0);
                run(7, lo, 255 - lo, x, 0, 0, 0);
                run(8, lo, 255, 0, x, 0, 1);
            end

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule